// File: doc/BRIEF.md
# FIFO-Threshold DMA Trigger Router

This block produces DMA request levels for a serial bus peripheral that can act as a controller or as a target, where each role has its own receive FIFO and transmit FIFO. It compares the four FIFO fill levels against four thresholds. Each threshold can be programmed on its own. Two independent trigger channels each pick one of those four comparisons through a 3-bit select index. The picked result drives that channel's DMA request line.

The block also accepts one done pulse per DMA channel. A done pulse sets a pair of sticky interrupt flags, the transmit-done and receive-done flags of the role whose condition the channel currently selects. Software clears the flags by pulsing write-one-to-clear bits.

Top module: `fifo_dma_trigger_router`

## Requirements
- R1: A select index picks the condition as follows: 1 = controller receive, 2 = controller transmit, 3 = target receive, 4 = target transmit.
- R2: A receive condition is true when the receive FIFO level is greater than or equal to its threshold.
- R3: A transmit condition is true when the transmit FIFO level is less than or equal to its threshold.
- R4: The two channels select independently. Both channels may select the same condition.
- R5: A select index of 0, 5, 6 or 7 holds that channel's request low.
- R6: Each request output is registered. It reflects levels, thresholds and select as sampled at the previous rising clock edge.
- R7: A done pulse on a channel that selects a controller condition sets both done_irq[0] (controller transmit done) and done_irq[1] (controller receive done) one cycle later.
- R8: A done pulse on a channel that selects a target condition sets both done_irq[2] (target transmit done) and done_irq[3] (target receive done) one cycle later.
- R9: The role comes from the channel's select value in the cycle of the done pulse. A done pulse on a disabled channel sets no flag.
- R10: Done flags hold until cleared. Bit i is cleared one cycle after irq_clr[i] is pulsed.
- R11: When a flag is set and cleared in the same cycle, the set wins.
- R12: After reset, both requests and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_rx_level | input | 4 | Controller receive FIFO fill level |
| ctl_tx_level | input | 4 | Controller transmit FIFO fill level |
| tgt_rx_level | input | 4 | Target receive FIFO fill level |
| tgt_tx_level | input | 4 | Target transmit FIFO fill level |
| ctl_rx_thresh | input | 4 | Controller receive threshold |
| ctl_tx_thresh | input | 4 | Controller transmit threshold |
| tgt_rx_thresh | input | 4 | Target receive threshold |
| tgt_tx_thresh | input | 4 | Target transmit threshold |
| ch0_sel | input | 3 | Condition select index for channel 0 |
| ch1_sel | input | 3 | Condition select index for channel 1 |
| dma_done | input | 2 | Done pulse from each DMA channel |
| irq_clr | input | 4 | Write-one-to-clear pulses for the done flags |
| dma_req | output | 2 | Request level for each channel (bit 1 is channel 1) |
| done_irq | output | 4 | Sticky done flags: ctl tx, ctl rx, tgt tx, tgt rx |

## Verification
Each request settles exactly one clock edge after its levels, thresholds or select change. The bench therefore samples requests twice: just after it drives new values, when the output must still show the previous vector, and again one edge later, when the new result is due. The done flags also move one edge after a done or clear pulse. The bench drives each pulse for one cycle between falling edges and reads the flags at the following falling edge, so that each check falls in the one cycle where the result is due.

// File: rtl/dmatrig_pkg.sv
package dmatrig_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CTL_RX = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CTL_TX = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TGT_RX = 3'd3;
    localparam logic [SEL_W-1:0] SEL_TGT_TX = 3'd4;

    // index of each source inside the condition vector
    localparam int SRC_CTL_RX = 0;
    localparam int SRC_CTL_TX = 1;
    localparam int SRC_TGT_RX = 2;
    localparam int SRC_TGT_TX = 3;
    localparam int N_SRC      = 4;

    // done flag bit positions
    localparam int FLG_CTL_TX = 0;
    localparam int FLG_CTL_RX = 1;
    localparam int FLG_TGT_TX = 2;
    localparam int FLG_TGT_RX = 3;
    localparam int N_FLG      = 4;

    typedef enum logic [1:0] {
        ROLE_NONE = 2'd0,
        ROLE_CTL  = 2'd1,
        ROLE_TGT  = 2'd2
    } role_e;

endpackage

// File: rtl/lvl_cmp.sv
module lvl_cmp #(
    parameter int LVL_W = 4,
    parameter bit IS_RX = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             hit
);
    generate
        if (IS_RX) begin : g_rx
            always_comb hit = (level >= thresh);
        end else begin : g_tx
            always_comb hit = (level <= thresh);
        end
    endgenerate
endmodule

// File: rtl/trig_channel.sv
module trig_channel
    import dmatrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-1:0] cond,
    output logic             req,
    output role_e            role
);
    typedef struct packed {
        logic req;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        role = ROLE_NONE;
        case (sel)
            SEL_CTL_RX: begin hit = cond[SRC_CTL_RX]; role = ROLE_CTL; end
            SEL_CTL_TX: begin hit = cond[SRC_CTL_TX]; role = ROLE_CTL; end
            SEL_TGT_RX: begin hit = cond[SRC_TGT_RX]; role = ROLE_TGT; end
            SEL_TGT_TX: begin hit = cond[SRC_TGT_TX]; role = ROLE_TGT; end
            default:    begin hit = 1'b0;             role = ROLE_NONE; end
        endcase
        st_d.req = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;

    // R5
    sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0 || sel > SEL_TGT_TX) |=> !req);

    // R1
    ctl_tx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTL_TX) |=> (req == $past(cond[SRC_CTL_TX])));

    // R1
    tgt_rx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_TGT_RX) |=> (req == $past(cond[SRC_TGT_RX])));
endmodule

// File: rtl/done_flag_bank.sv
module done_flag_bank
    import dmatrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_FLG-1:0] set,
    input  logic [N_FLG-1:0] clr,
    output logic [N_FLG-1:0] flags
);
    typedef struct packed {
        logic [N_FLG-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    generate
        for (genvar i = 0; i < N_FLG; i++) begin : g_chk
            // R11
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> flags[i]);
            // R10
            clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !flags[i]);
            // R10
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr[i] && !set[i]) |=> $stable(flags[i]));
        end
    endgenerate
endmodule

// File: rtl/fifo_dma_trigger_router.sv
module fifo_dma_trigger_router
    import dmatrig_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ctl_rx_level,
    input  logic [LVL_W-1:0] ctl_tx_level,
    input  logic [LVL_W-1:0] tgt_rx_level,
    input  logic [LVL_W-1:0] tgt_tx_level,
    input  logic [LVL_W-1:0] ctl_rx_thresh,
    input  logic [LVL_W-1:0] ctl_tx_thresh,
    input  logic [LVL_W-1:0] tgt_rx_thresh,
    input  logic [LVL_W-1:0] tgt_tx_thresh,
    input  logic [2:0]       ch0_sel,
    input  logic [2:0]       ch1_sel,
    input  logic [1:0]       dma_done,
    input  logic [3:0]       irq_clr,
    output logic [1:0]       dma_req,
    output logic [3:0]       done_irq
);
    localparam int N_CH = 2;

    logic [N_SRC-1:0][LVL_W-1:0] lvl, thr;
    logic [N_SRC-1:0]            cond;
    logic [N_CH-1:0][SEL_W-1:0]  sel;
    role_e                       role [N_CH];
    logic [N_FLG-1:0]            flag_set;

    assign lvl[SRC_CTL_RX] = ctl_rx_level;
    assign lvl[SRC_CTL_TX] = ctl_tx_level;
    assign lvl[SRC_TGT_RX] = tgt_rx_level;
    assign lvl[SRC_TGT_TX] = tgt_tx_level;
    assign thr[SRC_CTL_RX] = ctl_rx_thresh;
    assign thr[SRC_CTL_TX] = ctl_tx_thresh;
    assign thr[SRC_TGT_RX] = tgt_rx_thresh;
    assign thr[SRC_TGT_TX] = tgt_tx_thresh;
    assign sel[0] = ch0_sel;
    assign sel[1] = ch1_sel;

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            lvl_cmp #(
                .LVL_W (LVL_W),
                .IS_RX (s == SRC_CTL_RX || s == SRC_TGT_RX)
            ) u_cmp (
                .level  (lvl[s]),
                .thresh (thr[s]),
                .hit    (cond[s])
            );
        end
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            trig_channel u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .sel   (sel[c]),
                .cond  (cond),
                .req   (dma_req[c]),
                .role  (role[c])
            );
        end
    endgenerate

    always_comb begin
        flag_set = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (dma_done[c]) begin
                if (role[c] == ROLE_CTL) begin
                    flag_set[FLG_CTL_TX] = 1'b1;
                    flag_set[FLG_CTL_RX] = 1'b1;
                end else if (role[c] == ROLE_TGT) begin
                    flag_set[FLG_TGT_TX] = 1'b1;
                    flag_set[FLG_TGT_RX] = 1'b1;
                end
            end
        end
    end

    done_flag_bank u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (irq_clr),
        .flags (done_irq)
    );

    // R7
    ctl_done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done[0] && (ch0_sel == SEL_CTL_RX || ch0_sel == SEL_CTL_TX))
        |=> (done_irq[FLG_CTL_TX] && done_irq[FLG_CTL_RX]));

    // R8
    tgt_done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done[1] && (ch1_sel == SEL_TGT_RX || ch1_sel == SEL_TGT_TX))
        |=> (done_irq[FLG_TGT_TX] && done_irq[FLG_TGT_RX]));

    // R2
    rx_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_sel == SEL_CTL_RX && ctl_rx_level >= ctl_rx_thresh) |=> dma_req[0]);

    // R3
    tx_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_sel == SEL_TGT_TX && tgt_tx_level > tgt_tx_thresh) |=> !dma_req[1]);
endmodule

// File: tb/tb_fifo_dma_trigger_router.sv
module tb_fifo_dma_trigger_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] crl, ctl, trl, ttl, crt, ctt, trt, ttt;
    logic [2:0] s0, s1;
    logic [1:0] done;
    logic [3:0] clr;
    logic [1:0] req;
    logic [3:0] irq;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    fifo_dma_trigger_router dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_rx_level(crl), .ctl_tx_level(ctl), .tgt_rx_level(trl), .tgt_tx_level(ttl),
        .ctl_rx_thresh(crt), .ctl_tx_thresh(ctt), .tgt_rx_thresh(trt), .tgt_tx_thresh(ttt),
        .ch0_sel(s0), .ch1_sel(s1), .dma_done(done), .irq_clr(clr),
        .dma_req(req), .done_irq(irq)
    );

    typedef struct packed {
        logic [15:0] lv;   // {ctl rx, ctl tx, tgt rx, tgt tx}
        logic [15:0] th;
        logic [2:0]  a;
        logic [2:0]  b;
        logic [1:0]  exp;  // {ch1, ch0}
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{16'h4300, 16'h4200, 3'd1, 3'd2, 2'b01},  // R1 R2 rx equal, tx above
        '{16'h3200, 16'h4200, 3'd1, 3'd2, 2'b10},  // R2 rx below, R3 tx equal
        '{16'h0080, 16'h0080, 3'd3, 3'd4, 2'b11},  // R1 target full / empty
        '{16'h0071, 16'h0080, 3'd3, 3'd4, 2'b00},  // R2 R3 one off each way
        '{16'h8080, 16'h1414, 3'd0, 3'd5, 2'b00},  // R5 index 0 and 5
        '{16'h8080, 16'h1414, 3'd7, 3'd6, 2'b00},  // R5 index 7 and 6
        '{16'h8080, 16'h1414, 3'd4, 3'd1, 2'b11},  // R4 swapped roles
        '{16'h8080, 16'h1414, 3'd2, 3'd2, 2'b11},  // R4 same condition
        '{16'h8580, 16'h1414, 3'd2, 3'd1, 2'b10}   // R3 tx one above
    };

    task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", rq, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] d, input logic [3:0] c);
        @(negedge clk);
        done = d;
        clr  = c;
        @(negedge clk);
        done = '0;
        clr  = '0;
    endtask

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] prev;
        {crl, ctl, trl, ttl} = '0;
        {crt, ctt, trt, ttt} = '0;
        s0 = 3'd1; s1 = 3'd1; done = '0; clr = '0;
        repeat (3) @(negedge clk);
        check("R12 req", {2'b00, req}, 4'b0000);
        check("R12 flags", irq, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        prev = req;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {crl, ctl, trl, ttl} = VEC[i].lv;
            {crt, ctt, trt, ttt} = VEC[i].th;
            s0 = VEC[i].a;
            s1 = VEC[i].b;
            #2;
            check("R6 hold", {2'b00, req}, {2'b00, prev});
            @(negedge clk);
            check($sformatf("R1 R4 vec%0d", i), {2'b00, req}, {2'b00, VEC[i].exp});
            prev = VEC[i].exp;
        end

        // done flags: ch0 controller role, ch1 target role
        s0 = 3'd2; s1 = 3'd3;
        pulse(2'b01, 4'b0000);
        check("R7 ctl pair", irq, 4'b0011);
        pulse(2'b10, 4'b0000);
        check("R8 tgt pair", irq, 4'b1111);
        @(negedge clk);
        check("R10 sticky", irq, 4'b1111);
        pulse(2'b00, 4'b0001);
        check("R10 clear bit0", irq, 4'b1110);
        pulse(2'b01, 4'b0011);
        check("R11 set wins", irq, 4'b1111);
        pulse(2'b00, 4'b1111);
        check("R10 clear all", irq, 4'b0000);
        // R9 role follows current select
        s0 = 3'd4;
        pulse(2'b01, 4'b0000);
        check("R9 retarget", irq, 4'b1100);
        pulse(2'b00, 4'b1111);
        s0 = 3'd0; s1 = 3'd6;
        pulse(2'b11, 4'b0000);
        check("R9 disabled done", irq, 4'b0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule